// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block keeps the modem status byte of a 16550-compatible serial port. Four modem input lines (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through a short synchronizer. Their levels are held in the upper half of the status byte. Any change of level is recorded as a sticky delta bit in the lower half. A read strobe from the register interface returns the byte and then clears the delta bits.

The block also owns the five-bit modem control register. When the loopback bit of that register is set, the status levels come from the control outputs instead of the pins. A change flag, and a version of it gated by the modem-status interrupt enable, go to the interrupt logic of the port.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset the status byte reads 0xB0: carrier detect, data-set-ready and clear-to-send are high, ring indicator is low, and all delta bits are zero. The control register reads 0x08, with only the OUT2 bit set.
- R2: The upper nibble of the status byte holds the current levels: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring indicator, bit 7 carrier detect. A pin change reaches the byte on the third rising clock edge after it, two synchronizer edges plus one register edge.
- R3: Bits 0, 1 and 3 are the delta bits for clear-to-send, data-set-ready and carrier detect. Each is set on either edge of its line (new level XOR old level). Once set, it stays set until a read.
- R4: The ring indicator delta (bit 2) is set only when the ring level goes from 1 to 0. A rising ring level leaves it unchanged.
- R5: While `msr_rd` is high, `msr_q` shows the current byte. At that clock edge the delta bits are cleared, except for a change detected on the same edge, which is kept.
- R6: `ms_change` is high exactly while any delta bit is set. `ms_irq` equals `ms_change` AND `msi_en`.
- R7: While control bit 4 (loopback) is set, the levels come from the control bits: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2, carrier from bit 3. They are visible one edge after the control register holds the value.
- R8: In loopback the external modem lines have no effect on the status byte.
- R9: A write of the control register stores only `mcr_wdata[4:0]`. Bits 7..5 are dropped, and the value is visible on `mcr_q` after the write edge.
- R10: A level change that lasts a single clock still sets its delta bit, because every clock compares against the value of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in | input | 1 | Clear-to-send pin level |
| dsr_in | input | 1 | Data-set-ready pin level |
| ri_in | input | 1 | Ring indicator pin level |
| dcd_in | input | 1 | Carrier detect pin level |
| mcr_we | input | 1 | Control register write strobe |
| mcr_wdata | input | 8 | Control register write data |
| msr_rd | input | 1 | Status byte read strobe, one cycle per read |
| msi_en | input | 1 | Modem-status interrupt enable |
| mcr_q | output | 5 | Control register contents |
| msr_q | output | 8 | Status byte: levels in 7..4, deltas in 3..0 |
| ms_change | output | 1 | Any delta bit set |
| ms_irq | output | 1 | Change flag gated by the enable |

## Verification
The assertions assume that `msr_rd` is a single-cycle strobe per read and that the pins may change on any cycle. The delta properties compare registered level and delta state across one edge, so they need no limit on how often the pins toggle. The stimulus drives every input half a cycle away from the active edge. It mixes single-cycle pulses, reads that coincide with fresh changes, and writes of the control register both in and out of loopback.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int NLINES = 4;
  localparam int MCR_W  = 5;

  // level / delta nibble positions
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // control register bits
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  localparam logic [NLINES-1:0] LVL_RST = 4'b1011;
  localparam logic [MCR_W-1:0]  MCR_RST = 5'b01000;

  // status levels derived from the control outputs in loopback
  function automatic logic [NLINES-1:0] loop_levels(input logic [MCR_W-1:0] m);
    logic [NLINES-1:0] r;
    r[LN_CTS] = m[MC_RTS];
    r[LN_DSR] = m[MC_DTR];
    r[LN_RI]  = m[MC_OUT1];
    r[LN_DCD] = m[MC_OUT2];
    return r;
  endfunction

  // change events between two samples; ring counts only the trailing edge
  function automatic logic [NLINES-1:0] edge_events(input logic [NLINES-1:0] prev,
                                                    input logic [NLINES-1:0] cur);
    logic [NLINES-1:0] e;
    e        = prev ^ cur;
    e[LN_RI] = prev[LN_RI] & ~cur[LN_RI];
    return e;
  endfunction
endpackage

// File: rtl/mst_sync.sv
module mst_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else if (STAGES == 1) chain <= d[i];
        else chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mst_ctrl_reg.sv
module mst_ctrl_reg
  import mst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [MCR_W-1:0] wdata,
  output logic [MCR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= MCR_RST;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/mst_delta.sv
module mst_delta
  import mst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] src_lvl,
  input  logic              rd,
  output logic [NLINES-1:0] lvl_q,
  output logic [NLINES-1:0] delta_q,
  output logic [NLINES-1:0] evt
);
  assign evt = edge_events(lvl_q, src_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_RST;
      delta_q <= '0;
    end else begin
      lvl_q   <= src_lvl;
      delta_q <= rd ? evt : (delta_q | evt);
    end
  end

  // R3: deltas are sticky when no read
  p_delta_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R4: a rising ring level never creates the ring delta
  p_ri_rise_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_q[LN_RI] && src_lvl[LN_RI] && !delta_q[LN_RI] && !evt[LN_RI]) |=> !delta_q[LN_RI]);

  // R5: a read without a fresh change leaves no delta
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evt == '0) |=> delta_q == '0);

  // R10: any detected change is recorded on the next edge
  p_event_recorded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((delta_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import mst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  input  logic       mcr_we,
  input  logic [7:0] mcr_wdata,
  input  logic       msr_rd,
  input  logic       msi_en,
  output logic [4:0] mcr_q,
  output logic [7:0] msr_q,
  output logic       ms_change,
  output logic       ms_irq
);
  logic [NLINES-1:0] pins_raw, pins_s, loop_lvl, src_lvl, lvl_q, delta_q, evt;
  logic              loop_on;
  logic              unused_wdata_hi;

  assign pins_raw = {dcd_in, ri_in, dsr_in, cts_in};
  assign unused_wdata_hi = ^mcr_wdata[7:MCR_W];

  mst_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

  mst_ctrl_reg u_mcr (
    .clk(clk), .rst_n(rst_n), .we(mcr_we), .wdata(mcr_wdata[MCR_W-1:0]), .q(mcr_q));

  assign loop_on  = mcr_q[MC_LOOP];
  assign loop_lvl = loop_levels(mcr_q);
  assign src_lvl  = loop_on ? loop_lvl : pins_s;

  mst_delta u_delta (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .rd(msr_rd),
    .lvl_q(lvl_q), .delta_q(delta_q), .evt(evt));

  assign msr_q     = {lvl_q, delta_q};
  assign ms_change = |delta_q;
  assign ms_irq    = ms_change & msi_en;

  // R7: loopback levels track the control outputs one edge later
  p_loop_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |=> msr_q[7:4] == $past(loop_lvl));

  // R9: only the low control bits are stored
  p_mcr_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_we |=> mcr_q == $past(mcr_wdata[MCR_W-1:0]));

  // R6: the change flag rises only after a detected change
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ms_change) |-> $past(evt != '0));

  // R6: interrupt never without enable
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ms_irq |-> (msi_en && msr_q[3:0] != 4'h0));
endmodule

// File: tb/modem_status_tracker_bench.sv
module modem_status_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] ext = 4'b1011;  // {dcd, ri, dsr, cts}
  logic mcr_we = 0;
  logic [7:0] mcr_wdata = 0;
  logic msr_rd = 0;
  logic msi_en = 0;
  logic [4:0] mcr_q;
  logic [7:0] msr_q;
  logic ms_change, ms_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_tracker u_modem_status_tracker (
    .clk(clk), .rst_n(rst_n),
    .cts_in(ext[0]), .dsr_in(ext[1]), .ri_in(ext[2]), .dcd_in(ext[3]),
    .mcr_we(mcr_we), .mcr_wdata(mcr_wdata), .msr_rd(msr_rd), .msi_en(msi_en),
    .mcr_q(mcr_q), .msr_q(msr_q), .ms_change(ms_change), .ms_irq(ms_irq));

  // behavioural reference
  int m_pipe[$];
  int m_lvl, m_dlt, m_mcr;
  bit m_valid = 0;

  always @(posedge clk) begin
    int src, ch;
    if (!rst_n) begin
      m_pipe = {11, 11};
      m_lvl = 11; m_dlt = 0; m_mcr = 8; m_valid = 1;
    end else begin
      if (m_mcr >= 16)
        src = ((m_mcr >> 1) & 1) | ((m_mcr & 1) << 1) | (m_mcr & 4) | (m_mcr & 8);
      else
        src = m_pipe[1];
      ch = (src ^ m_lvl) & 11;
      if ((m_lvl & 4) != 0 && (src & 4) == 0) ch = ch | 4;
      m_dlt = msr_rd ? ch : (m_dlt | ch);
      m_lvl = src;
      m_pipe.pop_back();
      m_pipe.push_front(int'(ext));
      if (mcr_we) m_mcr = mcr_wdata % 32;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && m_valid && !finished) begin
      check("R2 R3 R4 R5 per-cycle status byte", int'(msr_q), m_lvl * 16 + m_dlt);
      check("R6 per-cycle change flag", int'(ms_change), int'(m_dlt != 0));
      check("R6 per-cycle irq", int'(ms_irq), int'(m_dlt != 0 && msi_en));
      check("R9 per-cycle control reg", int'(mcr_q), m_mcr);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    msr_rd = 1;
    wait_n(1);
    msr_rd = 0;
  endtask

  task automatic wr_mcr(input logic [7:0] v);
    mcr_we = 1; mcr_wdata = v;
    wait_n(1);
    mcr_we = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    check("R1 reset status", int'(msr_q), 'hB0);
    check("R1 reset control", int'(mcr_q), 'h08);
    check("R1 reset flag", int'(ms_change), 0);

    // R2/R3 clear-to-send falls
    ext[0] = 0;
    wait_n(2);
    check("R2 not yet visible after two edges", int'(msr_q[4]), 1);
    wait_n(1);
    check("R2 cts level low", int'(msr_q[4]), 0);
    check("R3 cts delta set", int'(msr_q[0]), 1);
    // R6 gating
    check("R6 irq masked", int'(ms_irq), 0);
    msi_en = 1;
    #1;
    check("R6 irq enabled", int'(ms_irq), 1);
    wait_n(2);
    check("R3 delta sticky", int'(msr_q[0]), 1);

    // R5 read returns then clears
    msr_rd = 1;
    #1;
    check("R5 read value", int'(msr_q), 'hA1);
    wait_n(1);
    msr_rd = 0;
    check("R5 deltas cleared", int'(msr_q[3:0]), 0);
    check("R6 flag low after read", int'(ms_change), 0);

    // R4 ring rise then fall
    ext[2] = 1;
    wait_n(3);
    check("R4 ring level high", int'(msr_q[6]), 1);
    check("R4 no delta on rise", int'(msr_q[2]), 0);
    ext[2] = 0;
    wait_n(3);
    check("R4 delta on fall", int'(msr_q[2]), 1);
    do_read();

    // R10 single-cycle pulse on data-set-ready
    ext[1] = 0;
    wait_n(1);
    ext[1] = 1;
    wait_n(5);
    check("R10 level restored", int'(msr_q[5]), 1);
    check("R10 pulse delta kept", int'(msr_q[1]), 1);

    // R5 read on same edge as a new change keeps that change
    ext[3] = 0;
    wait_n(2);
    msr_rd = 1;
    wait_n(1);
    msr_rd = 0;
    check("R5 fresh change survives read", int'(msr_q[3:0]), 'h8);
    do_read();

    // R9 reserved control bits dropped
    wr_mcr(8'hE0);
    check("R9 high bits dropped", int'(mcr_q), 0);
    wr_mcr(8'h03);
    check("R9 low bits kept", int'(mcr_q), 3);

    // R7 loopback mapping
    wr_mcr(8'h12);
    wait_n(1);
    check("R7 loop rts to cts", int'(msr_q[7:4]), 'h1);
    wr_mcr(8'h1D);
    wait_n(1);
    check("R7 loop dtr/out1/out2", int'(msr_q[7:4]), 'hE);
    do_read();
    check("R7 clean after read", int'(msr_q), 'hE0);

    // R8 external lines ignored in loopback
    ext = 4'b0000;
    wait_n(4);
    ext = 4'b1111;
    wait_n(4);
    check("R8 pins ignored", int'(msr_q), 'hE0);

    // leave loopback, pins take over
    wr_mcr(8'h08);
    wait_n(3);
    check("R2 pins after loopback", int'(msr_q[7:4]), 'hF);

    wait_n(4);
    finish_run();
  end
endmodule